// File: doc/BRIEF.md
# Bit-Serial SIMD Processing Element Array

This block is a row of one-bit processing elements (PEs) that execute in lockstep. Every clock, a controller presents one instruction made of a 5-bit operation code and a 9-bit bit address. All PEs decode the same operation and read the same bit position of their own private one-bit-wide memory. Each PE holds three one-bit registers. The accumulator A feeds the outgoing switch path. The mask M gates memory writes. The carry B links successive bit steps of an arithmetic operation.

Multi-bit arithmetic is not built into the hardware. A controller issues one add or subtract step per bit, least significant bit first, while the carry travels in B. The controller chooses the operand width freely. Writing B out after the last step gives an n-bit add an exact (n+1)-bit result. Data enters a PE through its one-bit input from the switch and leaves through A, which drives the one-bit output to the switch.

Top module: `simd_pe_array`

## Requirements
- R1: While reset is high, and on the first edge after it, the A, M and B registers of every PE are 0. The switch output therefore reads 0.
- R2: The switch output of each PE always equals its A register. Operation code 2 loads A from that PE's switch input bit.
- R3: Code 1 loads A from the memory bit at the broadcast address. Code 8 writes A into that bit. The 9-bit address selects the same bit position in every PE.
- R4: Code 8 (and every other memory-writing code) changes a PE's memory bit only when that PE's M is 1. Code 3 loads M from memory, code 4 copies A into M, and code 5 sets M to 1.
- R5: Code 6 clears B and code 7 sets B. Code 16 copies B into A. Code 9 writes B into the addressed memory bit, subject to the mask.
- R6: The logic operations are: code 10 sets A to NOT A; codes 11, 12 and 13 set A to A OR mem, A AND mem and A XOR mem.
- R7: Code 14 is an add step. It writes A^mem^B into memory (masked), sets B to the majority of A, mem and B, and leaves A unchanged.
- R8: Code 15 is a subtract step. It writes A^~mem^B into memory (masked) and sets B to the majority of A, ~mem and B. A is the minuend and B is the not-borrow.
- R9: Clearing B, then running eight pairs of "load A from X bit i, add step at Y bit i", then copying B to A and storing it at Y bit 8, leaves the exact 9-bit sum X+Y in Y in every PE.
- R10: Setting B, then running eight pairs of "load A from X bit i, subtract step at Y bit i", leaves (X-Y) mod 256 in Y. B then holds 1 exactly when X >= Y.
- R11: Code 0 and codes 17 to 31 change no register and no memory bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 5 | Broadcast operation code |
| op_addr | input | 9 | Broadcast memory bit address |
| sw_in | input | NUM_PE | One bit per PE from the switch |
| sw_out | output | NUM_PE | One bit per PE to the switch (the A registers) |

## Verification
The bench builds the array with its default values: 16 PEs, each with 512 memory bits. Sixteen lanes are enough to give every PE a different operand pair in the same run. They also leave room for the corner lanes: 255+255, 0+0, equal operands and a minuend smaller than the subtrahend. With the full 512-bit depth, the operand, result and mask rows can sit far apart, so each test's writes go to addresses that no other test uses.

// File: rtl/simd_pe_pkg.sv
package simd_pe_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_NOP      = 5'd0,
        OP_LDA_MEM  = 5'd1,
        OP_LDA_SW   = 5'd2,
        OP_LDM_MEM  = 5'd3,
        OP_LDM_A    = 5'd4,
        OP_SET_M    = 5'd5,
        OP_CLR_B    = 5'd6,
        OP_SET_B    = 5'd7,
        OP_ST_A     = 5'd8,
        OP_ST_B     = 5'd9,
        OP_NOT_A    = 5'd10,
        OP_OR_A     = 5'd11,
        OP_AND_A    = 5'd12,
        OP_XOR_A    = 5'd13,
        OP_ADD_STEP = 5'd14,
        OP_SUB_STEP = 5'd15,
        OP_LDA_B    = 5'd16
    } pe_op_e;

    typedef enum logic [2:0] {
        A_HOLD, A_MEM, A_SW, A_NOT, A_OR, A_AND, A_XOR, A_FROM_B
    } a_sel_e;

    typedef enum logic [1:0] {
        M_HOLD, M_MEM, M_FROM_A, M_ONE
    } m_sel_e;

    typedef enum logic [1:0] {
        B_HOLD, B_ZERO, B_ONE, B_CARRY
    } b_sel_e;

    typedef enum logic [1:0] {
        W_NONE, W_A, W_B, W_SUM
    } w_sel_e;

    typedef struct packed {
        a_sel_e a_sel;
        m_sel_e m_sel;
        b_sel_e b_sel;
        w_sel_e w_sel;
        logic   inv_mem;
    } pe_ctrl_t;

    localparam pe_ctrl_t CTRL_IDLE = '{a_sel: A_HOLD, m_sel: M_HOLD,
                                       b_sel: B_HOLD, w_sel: W_NONE,
                                       inv_mem: 1'b0};

    function automatic pe_ctrl_t decode_op(input logic [OP_W-1:0] code);
        pe_ctrl_t c;
        c = CTRL_IDLE;
        case (code)
            OP_LDA_MEM:  c.a_sel = A_MEM;
            OP_LDA_SW:   c.a_sel = A_SW;
            OP_LDM_MEM:  c.m_sel = M_MEM;
            OP_LDM_A:    c.m_sel = M_FROM_A;
            OP_SET_M:    c.m_sel = M_ONE;
            OP_CLR_B:    c.b_sel = B_ZERO;
            OP_SET_B:    c.b_sel = B_ONE;
            OP_ST_A:     c.w_sel = W_A;
            OP_ST_B:     c.w_sel = W_B;
            OP_NOT_A:    c.a_sel = A_NOT;
            OP_OR_A:     c.a_sel = A_OR;
            OP_AND_A:    c.a_sel = A_AND;
            OP_XOR_A:    c.a_sel = A_XOR;
            OP_ADD_STEP: begin
                c.b_sel = B_CARRY;
                c.w_sel = W_SUM;
            end
            OP_SUB_STEP: begin
                c.b_sel   = B_CARRY;
                c.w_sel   = W_SUM;
                c.inv_mem = 1'b1;
            end
            OP_LDA_B:    c.a_sel = A_FROM_B;
            default:     c = CTRL_IDLE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/simd_pe_decode.sv
module simd_pe_decode
    import simd_pe_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    output pe_ctrl_t        ctrl
);
    // One shared decoder drives the control word into every PE.
    always_comb ctrl = decode_op(op_code);
endmodule

// File: rtl/simd_pe_alu.sv
module simd_pe_alu
    import simd_pe_pkg::*;
(
    input  pe_ctrl_t ctrl,
    input  logic     a_q,
    input  logic     m_q,
    input  logic     b_q,
    input  logic     mem_bit,
    input  logic     sw_bit,
    output logic     a_nxt,
    output logic     m_nxt,
    output logic     b_nxt,
    output logic     wr_en,
    output logic     wr_bit
);
    logic opnd;
    logic sum;
    logic carry;

    always_comb begin
        opnd  = mem_bit ^ ctrl.inv_mem;
        sum   = a_q ^ opnd ^ b_q;
        carry = (a_q & opnd) | (a_q & b_q) | (opnd & b_q);

        case (ctrl.a_sel)
            A_MEM:    a_nxt = mem_bit;
            A_SW:     a_nxt = sw_bit;
            A_NOT:    a_nxt = ~a_q;
            A_OR:     a_nxt = a_q | mem_bit;
            A_AND:    a_nxt = a_q & mem_bit;
            A_XOR:    a_nxt = a_q ^ mem_bit;
            A_FROM_B: a_nxt = b_q;
            default:  a_nxt = a_q;
        endcase

        case (ctrl.m_sel)
            M_MEM:    m_nxt = mem_bit;
            M_FROM_A: m_nxt = a_q;
            M_ONE:    m_nxt = 1'b1;
            default:  m_nxt = m_q;
        endcase

        case (ctrl.b_sel)
            B_ZERO:  b_nxt = 1'b0;
            B_ONE:   b_nxt = 1'b1;
            B_CARRY: b_nxt = carry;
            default: b_nxt = b_q;
        endcase

        case (ctrl.w_sel)
            W_A:     wr_bit = a_q;
            W_B:     wr_bit = b_q;
            W_SUM:   wr_bit = sum;
            default: wr_bit = 1'b0;
        endcase
        wr_en = (ctrl.w_sel != W_NONE) && m_q;
    end
endmodule

// File: rtl/simd_pe_cell.sv
module simd_pe_cell
    import simd_pe_pkg::*;
#(
    parameter int MEM_DEPTH = 512,
    parameter int ADDR_W    = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  pe_ctrl_t          ctrl,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sw_bit,
    output logic              a_q,
    output logic              m_q,
    output logic              b_q
);
    logic [MEM_DEPTH-1:0] mem_q;
    logic mem_bit;
    logic a_nxt, m_nxt, b_nxt, wr_en, wr_bit;

    assign mem_bit = mem_q[addr];

    simd_pe_alu u_alu (
        .ctrl    (ctrl),
        .a_q     (a_q),
        .m_q     (m_q),
        .b_q     (b_q),
        .mem_bit (mem_bit),
        .sw_bit  (sw_bit),
        .a_nxt   (a_nxt),
        .m_nxt   (m_nxt),
        .b_nxt   (b_nxt),
        .wr_en   (wr_en),
        .wr_bit  (wr_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= 1'b0;
            m_q <= 1'b0;
            b_q <= 1'b0;
        end else begin
            a_q <= a_nxt;
            m_q <= m_nxt;
            b_q <= b_nxt;
        end
    end

    // Storage carries no reset: its contents are only defined once written.
    always_ff @(posedge clk) begin
        if (!rst && wr_en) mem_q[addr] <= wr_bit;
    end
endmodule

// File: rtl/simd_pe_array.sv
module simd_pe_array
    import simd_pe_pkg::*;
#(
    parameter int NUM_PE    = 16,
    parameter int MEM_DEPTH = 512,
    parameter int ADDR_W    = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_code,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [NUM_PE-1:0] sw_in,
    output logic [NUM_PE-1:0] sw_out
);
    pe_ctrl_t          ctrl;
    logic [NUM_PE-1:0] a_vec;
    logic [NUM_PE-1:0] m_vec;
    logic [NUM_PE-1:0] b_vec;

    simd_pe_decode u_dec (
        .op_code (op_code),
        .ctrl    (ctrl)
    );

    for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
        simd_pe_cell #(
            .MEM_DEPTH (MEM_DEPTH),
            .ADDR_W    (ADDR_W)
        ) u_cell (
            .clk    (clk),
            .rst    (rst),
            .ctrl   (ctrl),
            .addr   (op_addr),
            .sw_bit (sw_in[p]),
            .a_q    (a_vec[p]),
            .m_q    (m_vec[p]),
            .b_q    (b_vec[p])
        );
    end

    assign sw_out = a_vec;
endmodule

// File: rtl/simd_pe_array_chk.sv
module simd_pe_array_chk
    import simd_pe_pkg::*;
#(
    parameter int NUM_PE = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   op_code,
    input logic [NUM_PE-1:0] sw_in,
    input logic [NUM_PE-1:0] sw_out,
    input logic [NUM_PE-1:0] m_vec,
    input logic [NUM_PE-1:0] b_vec
);
    logic rst_seen_q = 1'b0;
    always_ff @(posedge clk) rst_seen_q <= rst;

    always @(negedge clk) begin
        if (rst_seen_q)
            AST_RESET_CLEAR: assert (sw_out == '0 && m_vec == '0 && b_vec == '0); // R1
    end

    AST_SW_LOAD: assert property (@(posedge clk) disable iff (rst)
        op_code == OP_LDA_SW |=> sw_out == $past(sw_in)); // R2

    AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
        op_code == OP_SET_M |=> m_vec == '1); // R4

    AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        op_code == OP_CLR_B |=> b_vec == '0); // R5

    AST_CARRY_SET: assert property (@(posedge clk) disable iff (rst)
        op_code == OP_SET_B |=> b_vec == '1); // R5

    AST_NOT_ACC: assert property (@(posedge clk) disable iff (rst)
        op_code == OP_NOT_A |=> sw_out == ~$past(sw_out)); // R6

    AST_STEP_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_ADD_STEP || op_code == OP_SUB_STEP) |=> $stable(sw_out)); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_NOP || op_code > OP_LDA_B)
        |=> ($stable(sw_out) && $stable(m_vec) && $stable(b_vec))); // R11
endmodule

bind simd_pe_array simd_pe_array_chk #(.NUM_PE(NUM_PE)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_code (op_code),
    .sw_in   (sw_in),
    .sw_out  (sw_out),
    .m_vec   (m_vec),
    .b_vec   (b_vec)
);

// File: tb/test_simd_pe_array.sv
`timescale 1ns/1ps
module test_simd_pe_array;
    import simd_pe_pkg::*;

    localparam int NUM_PE    = 16;
    localparam int MEM_DEPTH = 512;
    localparam int ADDR_W    = $clog2(MEM_DEPTH);
    typedef logic [NUM_PE-1:0] row_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [OP_W-1:0]   op_code = '0;
    logic [ADDR_W-1:0] op_addr = '0;
    row_t              sw_in = '0;
    row_t              sw_out;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    simd_pe_array #(.NUM_PE(NUM_PE), .MEM_DEPTH(MEM_DEPTH)) i_simd_pe_array (
        .clk     (clk),
        .rst     (rst),
        .op_code (op_code),
        .op_addr (op_addr),
        .sw_in   (sw_in),
        .sw_out  (sw_out)
    );

    logic [7:0]  xv [NUM_PE];
    logic [7:0]  yv [NUM_PE];
    logic [15:0] rv [NUM_PE];

    task automatic chk(input string req, input string what, input row_t act, input row_t exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_word(input string req, input int lane, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s lane %0d: actual=%0d expected=%0d", req, lane, act, exp);
        end
    endtask

    // Present one instruction; returns on the next falling edge, after the update.
    task automatic issue(input logic [OP_W-1:0] op, input int addr, input row_t sw);
        op_code = op;
        op_addr = ADDR_W'(addr);
        sw_in   = sw;
        @(negedge clk);
        op_code = OP_NOP;
    endtask

    task automatic put_row(input int addr, input row_t v);
        issue(OP_SET_M, 0, '0);
        issue(OP_LDA_SW, 0, v);
        issue(OP_ST_A, addr, '0);
    endtask

    task automatic get_row(input int addr, output row_t v);
        issue(OP_LDA_MEM, addr, '0);
        v = sw_out;
    endtask

    task automatic put_bytes(input int base, input logic [7:0] v [NUM_PE]);
        for (int i = 0; i < 8; i++) begin
            row_t r;
            for (int p = 0; p < NUM_PE; p++) r[p] = v[p][i];
            put_row(base + i, r);
        end
    endtask

    task automatic get_bits(input int base, input int n);
        for (int p = 0; p < NUM_PE; p++) rv[p] = '0;
        for (int i = 0; i < n; i++) begin
            row_t r;
            get_row(base + i, r);
            for (int p = 0; p < NUM_PE; p++) rv[p][i] = r[p];
        end
    endtask

    task automatic t_reset;
        chk("R1", "acc after reset", sw_out, '0);
        issue(OP_LDA_B, 0, '0);
        chk("R1", "carry after reset", sw_out, '0);
    endtask

    task automatic t_switch_load;
        issue(OP_LDA_SW, 0, 16'hA5C3);
        chk("R2", "load from switch", sw_out, 16'hA5C3);
        issue(OP_LDA_SW, 0, 16'h0F0F);
        chk("R2", "load from switch 2", sw_out, 16'h0F0F);
    endtask

    task automatic t_mem_rw;
        row_t r;
        put_row(0, 16'h1234);
        put_row(511, 16'hFEDC);
        get_row(0, r);
        chk("R3", "bit 0 readback", r, 16'h1234);
        get_row(511, r);
        chk("R3", "bit 511 readback", r, 16'hFEDC);
    endtask

    task automatic t_mask;
        row_t r;
        put_row(100, 16'h6C39);
        put_row(200, 16'h0000);
        issue(OP_LDM_MEM, 100, '0);
        issue(OP_LDA_SW, 0, 16'hFFFF);
        issue(OP_ST_A, 200, '0);
        get_row(200, r);
        chk("R4", "write under memory mask", r, 16'h6C39);
        issue(OP_LDA_SW, 0, 16'h00FF);
        issue(OP_LDM_A, 0, '0);
        issue(OP_LDA_SW, 0, 16'h0000);
        issue(OP_ST_A, 200, '0);
        get_row(200, r);
        chk("R4", "write under A-copied mask", r, 16'h6C00);
    endtask

    task automatic t_carry;
        row_t r;
        issue(OP_SET_B, 0, '0);
        issue(OP_LDA_B, 0, '0);
        chk("R5", "set carry", sw_out, '1);
        put_row(210, 16'h0000);
        issue(OP_ST_B, 210, '0);
        get_row(210, r);
        chk("R5", "store carry", r, '1);
        issue(OP_CLR_B, 0, '0);
        issue(OP_LDA_B, 0, '0);
        chk("R5", "clear carry", sw_out, '0);
    endtask

    task automatic t_logic;
        row_t p = 16'hC3A5;
        row_t q = 16'h5AF0;
        put_row(300, p);
        put_row(301, q);
        issue(OP_LDA_MEM, 300, '0);
        issue(OP_OR_A, 301, '0);
        chk("R6", "or", sw_out, p | q);
        issue(OP_LDA_MEM, 300, '0);
        issue(OP_AND_A, 301, '0);
        chk("R6", "and", sw_out, p & q);
        issue(OP_XOR_A, 301, '0);
        chk("R6", "xor", sw_out, (p & q) ^ q);
        issue(OP_NOT_A, 0, '0);
        chk("R6", "not", sw_out, ~((p & q) ^ q));
    endtask

    task automatic t_add;
        for (int p = 0; p < NUM_PE; p++) begin
            xv[p] = 8'(p * 37 + 11);
            yv[p] = 8'(p * 91 + 200);
        end
        xv[0] = 8'd255; yv[0] = 8'd255;
        xv[1] = 8'd0;   yv[1] = 8'd0;
        put_bytes(16, xv);
        put_bytes(32, yv);
        issue(OP_SET_M, 0, '0);
        issue(OP_CLR_B, 0, '0);
        for (int i = 0; i < 8; i++) begin
            issue(OP_LDA_MEM, 16 + i, '0);
            issue(OP_ADD_STEP, 32 + i, '0);
        end
        issue(OP_LDA_B, 0, '0);
        issue(OP_ST_A, 40, '0);
        get_bits(32, 9);
        for (int p = 0; p < NUM_PE; p++)
            chk_word("R7/R9 add", p, int'(rv[p]), int'(xv[p]) + int'(yv[p]));
        get_bits(16, 8);
        for (int p = 0; p < NUM_PE; p++)
            chk_word("R7 addend kept", p, int'(rv[p]), int'(xv[p]));
    endtask

    task automatic t_sub;
        row_t nb;
        for (int p = 0; p < NUM_PE; p++) begin
            xv[p] = 8'(p * 53 + 7);
            yv[p] = 8'(p * 29 + 90);
        end
        xv[2] = 8'd77;  yv[2] = 8'd77;
        xv[3] = 8'd0;   yv[3] = 8'd255;
        put_bytes(64, xv);
        put_bytes(80, yv);
        issue(OP_SET_M, 0, '0);
        issue(OP_SET_B, 0, '0);
        for (int i = 0; i < 8; i++) begin
            issue(OP_LDA_MEM, 64 + i, '0);
            issue(OP_SUB_STEP, 80 + i, '0);
        end
        issue(OP_LDA_B, 0, '0);
        for (int p = 0; p < NUM_PE; p++) nb[p] = (xv[p] >= yv[p]);
        chk("R8/R10", "not-borrow", sw_out, nb);
        get_bits(80, 8);
        for (int p = 0; p < NUM_PE; p++)
            chk_word("R8/R10 sub", p, int'(rv[p]), int'(8'(xv[p] - yv[p])));
    endtask

    task automatic t_idle;
        row_t r;
        put_row(400, 16'h3C3C);
        issue(OP_SET_B, 0, '0);
        issue(OP_LDA_SW, 0, 16'h9999);
        issue(OP_LDM_A, 0, '0);
        issue(OP_LDA_SW, 0, 16'h5A5A);
        for (int c = 17; c < 32; c++) issue(OP_W'(c), 400, 16'hFFFF);
        issue(OP_NOP, 400, 16'hFFFF);
        chk("R11", "acc held", sw_out, 16'h5A5A);
        issue(OP_ST_A, 401, '0);
        issue(OP_LDA_B, 0, '0);
        chk("R11", "carry held", sw_out, '1);
        get_row(400, r);
        chk("R11", "memory held", r, 16'h3C3C);
        issue(OP_LDA_SW, 0, 16'hFFFF);
        issue(OP_ST_A, 402, '0);
        get_row(402, r);
        chk("R11", "mask held", r & 16'h9999, 16'h9999);
    endtask

    initial begin
        #(8ns * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_switch_load();
        t_mem_rw();
        t_mask();
        t_carry();
        t_logic();
        t_add();
        t_sub();
        t_idle();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule